// File: doc/BRIEF.md
# Dedicated Input Pin Conditioning Cell

This cell sits between an input-only pin and the on-chip routing network. It hands the pin value to the routing network in one of four ways. It can pass the value straight through. It can capture it in one flip-flop. It can capture it in two flip-flops in series, which is useful for synchronising a pin that changes without reference to the chip's clocks. It can also hold it in a level-sensitive latch.

For every storage option, a configuration field picks one of four capture clocks. A polarity bit chooses the active edge, or the active level, of that clock. When the cell is built as clock-capable, it also drives the pin value onto a clock distribution output, and the same polarity bit inverts that output.

The whole cell runs in one fast sampling clock domain. It treats the four capture clocks as ordinary signals and finds their active edges by comparing each sample with the one before. Every stored value resets to zero, and the data output is held at zero for as long as reset is asserted.

Top module: `pin_input_cell`

## Requirements
- R1: With `mode` = 0 (pass-through), `route_out` equals `pin` in the same cycle.
- R2: With `mode` = 1 (single register), `route_out` takes the value `pin` had at the active edge of the selected capture clock. The new value appears one sampling cycle after that edge is sampled, and `route_out` does not change between edges.
- R3: With `mode` = 2 (double register), each active edge shifts `pin` into the first stage and the first stage into the second. `route_out` shows the second stage, so a pin value reaches the output after two active edges.
- R4: With `mode` = 3 (latch), `route_out` follows `pin` while the selected capture clock is at its active level. It holds the last value seen at the active level once that clock goes inactive.
- R5: Only the capture clock indexed by `clk_sel` (0 to 3) affects storage. Activity on any other capture clock leaves `route_out` unchanged.
- R6: With `pol` = 0, the active edge is rising and the active level is high. With `pol` = 1, the active edge is falling and the active level is low.
- R7: In a clock-capable instance, `clk_feed` equals `pin` XOR `pol` at all times.
- R8: While `rst_n` is low, `route_out` is 0. Every storage element is cleared, so a registered mode shows 0 until its first capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin | input | 1 | Pin value |
| cap_clk | input | NCLK | Selectable capture clocks |
| clk_sel | input | SEL_W | Index of the capture clock in use |
| mode | input | 2 | 0 pass-through, 1 register, 2 double register, 3 latch |
| pol | input | 1 | Capture and feed polarity (1 = falling edge / low level, inverted feed) |
| route_out | output | 1 | Conditioned value to routing |
| clk_feed | output | 1 | Polarity-adjusted pin value onto the clock network |

## Verification
The assertions check three things on every cycle. Both register stages hold their values whenever no selected edge is seen. The second stage always takes the previous value of the first stage at an edge. The latch copies the pin while its level is active. The output is also checked to be zero throughout reset.

Only the bench scenarios can show the end-to-end latencies, and they do so across every mode, clock index and polarity. They also show that pulses on unselected clocks change nothing at the output, and that the latch stays transparent when the pin changes in the middle of an active phase.

// File: rtl/pin_input_cell.sv
module pin_input_cell #(
  parameter int NCLK = 4,
  parameter bit CLK_CAPABLE = 1'b1,
  localparam int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [NCLK-1:0]  cap_clk,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [1:0]       mode,
  input  logic             pol,
  output logic             route_out,
  output logic             clk_feed
);

  localparam logic [1:0] M_PASS  = 2'd0;
  localparam logic [1:0] M_REG   = 2'd1;
  localparam logic [1:0] M_DBL   = 2'd2;
  localparam logic [1:0] M_LATCH = 2'd3;

  logic lvl, lvl_q, edge_hit;
  logic stage1, stage2, held;
  logic data_sel;

  assign lvl      = cap_clk[clk_sel] ^ pol;
  assign edge_hit = lvl & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      stage1 <= 1'b0;
      stage2 <= 1'b0;
      held   <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (edge_hit) begin
        stage1 <= pin;
        stage2 <= stage1;
      end
      if (lvl) held <= pin;
    end
  end

  always_comb begin
    case (mode)
      M_PASS:  data_sel = pin;
      M_REG:   data_sel = stage1;
      M_DBL:   data_sel = stage2;
      default: data_sel = lvl ? pin : held;
    endcase
  end

  assign route_out = rst_n & data_sel;

  generate
    if (CLK_CAPABLE) begin : g_feed
      assign clk_feed = pin ^ pol;
    end else begin : g_nofeed
      assign clk_feed = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!rst_n) a_r8_zero_in_reset: assert (route_out == 1'b0);
  end

  a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_hit |=> $stable(stage1) && $stable(stage2));

  a_r3_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (stage2 == $past(stage1)) && (stage1 == $past(pin)));

  a_r4_latch_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    lvl |=> (held == $past(pin)));

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |=> $stable(held));

endmodule

// File: tb/pin_input_cell_tb.sv
module pin_input_cell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic [3:0] cap_clk = 4'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [1:0] mode = 2'd0;
  logic pol = 1'b0;
  logic route_out, clk_feed;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  pin_input_cell u_dut (
    .clk(clk), .rst_n(rst_n), .pin(pin), .cap_clk(cap_clk), .clk_sel(clk_sel),
    .mode(mode), .pol(pol), .route_out(route_out), .clk_feed(clk_feed)
  );

  always #2.5 clk = ~clk;

  logic e1, e2, le;

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s mode=%0d sel=%0d pol=%0d actual=%b expected=%b",
               req, mode, clk_sel, pol, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic held_exp();
    case (mode)
      2'd0: return pin;
      2'd1: return e1;
      2'd2: return e2;
      default: return le;
    endcase
  endfunction

  task automatic out_check();
    #0.5;
    case (mode)
      2'd0: check("R1 pass-through", route_out, pin);
      2'd1: check("R2 single register", route_out, e1);
      2'd2: check("R3 double register", route_out, e2);
      default: check("R4 latch hold", route_out, le);
    endcase
    check("R7 clock feed", clk_feed, pin ^ pol);
  endtask

  task automatic pulse_sel(input logic a, input logic b);
    pin = a;
    cap_clk[clk_sel] = ~pol;
    tick();
    pin = b;
    #0.5;
    if (mode == 2'd3) check("R4 latch transparent R6", route_out, b);
    tick();
    cap_clk[clk_sel] = pol;
    e2 = e1;
    e1 = a;
    le = b;
    tick();
    out_check();
  endtask

  task automatic pulse_other(input logic v);
    logic [1:0] o;
    o = clk_sel + 2'd1;
    pin = v;
    cap_clk[o] = ~pol;
    tick();
    tick();
    cap_clk[o] = pol;
    tick();
    #0.5;
    if (mode != 2'd0) check("R5 unselected clock ignored", route_out, held_exp());
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 2; p++) begin
          rst_n = 1'b0;
          mode = m[1:0];
          clk_sel = s[1:0];
          pol = p[0];
          cap_clk = {4{p[0]}};
          cap_clk[s] = ~p[0];
          pin = 1'b1;
          #3;
          check("R8 output zero in reset", route_out, 1'b0);
          cap_clk = {4{p[0]}};
          tick();
          rst_n = 1'b1;
          e1 = 1'b0; e2 = 1'b0; le = 1'b0;
          tick();
          out_check();
          pulse_sel(1'b1, 1'b0);
          pulse_other(1'b0);
          pulse_sel(1'b0, 1'b1);
          pulse_other(1'b1);
          pulse_sel(1'b1, 1'b1);
          pulse_sel(1'b0, 1'b0);
          pulse_other(1'b1);
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule